// File: doc/BRIEF.md
# Cascaded Search Result Delay Pipeline

This block sits in every device of a lookup table that is split across several devices in depth. Each clock a device may start a search; the block takes that search's local outcome (hit or miss, and the index of the matching entry), plus a signal saying that another device in the cascade claimed the same search. It then holds the outcome until the table-wide answer time and drives it onto the shared result flags and the shared SRAM address and strobe pins. Each shared pin group has an output enable, so only one device drives it at a time.

Two fields set the timing. A 2-bit table-size code sets the base delay to 4, 5 or 6 clocks, and the SRAM pins follow that delay. A 3-bit extra-delay code holds the found and valid flags back by a further 0 to 7 clocks. Two flags pick the devices that drive the idle values. One marks the device that owns the result flags when no device hits. The other marks the device that owns the SRAM pins when no device drives them and that always drives the SRAM output-enable strobe. The configuration stays fixed while searches run; a change is followed by a reset.

Top module: `cascade_result_delay`

## Requirements
- R1: A search presented in cycle c shows its SRAM address and strobes in cycle c+L, where L is 4 for table-size code 00, 5 for 01 and 6 for 10.
- R2: Table-size code 11 is treated as L = 6 and raises `cfg_err`; every other code keeps `cfg_err` low.
- R3: The found and valid flags for a search presented in cycle c appear in cycle c+L+H, where H is the 0-to-7 value of the extra-delay code; the SRAM pins do not move with H.
- R4: A search that hits locally with `peer_claim` low is a win. In its flag cycle the device drives `flag_oe`=1, `hit_found`=1 and `hit_valid`=1, and it does so in that cycle only.
- R5: With `cfg_last_dev`=1, a search that missed locally with `peer_claim` low gives `flag_oe`=1, `hit_found`=0, `hit_valid`=1 in its flag cycle.
- R6: With `cfg_last_dev`=1, a flag cycle that carries no search gives `flag_oe`=1 with both flags 0. A flag cycle whose search was claimed by another device gives `flag_oe`=0.
- R7: With `cfg_last_dev`=0, every flag cycle without a local win has `flag_oe`=0, and both flags read 0.
- R8: In the SRAM cycle of a win the device drives `sram_drive`=1, `sram_addr` equal to the search index, and `sram_ce_n`=0, `sram_ale_n`=0, `sram_we_n`=1.
- R9: Without a local win, `sram_addr` is all ones and `sram_ce_n`, `sram_we_n`, `sram_ale_n` are 1. `sram_drive` is 1 only when `cfg_last_bus`=1 and no other device claimed that search.
- R10: `sram_oe_drive` equals `cfg_last_bus` in every cycle. `sram_oe_n` is 0 exactly in SRAM cycles whose search was won by this device or claimed by another, and 1 otherwise.
- R11: A new search is accepted every clock. Back-to-back searches come out in issue order, one per cycle, with no gaps.
- R12: After a synchronous reset no search is in flight, and all outputs show the idle values of R6, R7, R9 and R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_table_size | input | 2 | Table-size code that sets the base delay |
| cfg_hit_delay | input | 3 | Extra flag delay in clocks |
| cfg_last_dev | input | 1 | Device owns the result flags when no device hits |
| cfg_last_bus | input | 1 | Device owns the idle SRAM pins and the SRAM output-enable strobe |
| req_valid | input | 1 | A search starts this cycle |
| req_hit | input | 1 | Local outcome of that search is a hit |
| req_index | input | 22 | Index of the matching entry |
| peer_claim | input | 1 | Another device claims this search |
| hit_found | output | 1 | Found flag |
| hit_valid | output | 1 | Result-valid flag |
| flag_oe | output | 1 | Output enable for the two flags |
| sram_addr | output | 22 | SRAM address |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_ale_n | output | 1 | SRAM address latch enable, active low |
| sram_drive | output | 1 | Output enable for address, chip, write and latch strobes |
| sram_oe_n | output | 1 | SRAM output enable strobe, active low |
| sram_oe_drive | output | 1 | Output enable for `sram_oe_n` |
| cfg_err | output | 1 | Reserved table-size code selected |

## Verification
A search presented in cycle c is due on the SRAM pins in cycle c+L and on the flags in cycle c+L+H, with L and H taken from the codes as stated above. The bench drives a new search every cycle and keeps a record of them by cycle number. At each falling edge it compares the outputs with the search recorded L (and L+H) cycles earlier; a cycle that maps to before the first search or after the last one is expected to be idle. This is done for all 128 combinations of table size, extra delay and the two ownership flags, so any timing that is off by one clock shows up as a mismatch in the content.

// File: rtl/csr_pkg.sv
package csr_pkg;
    // Shared widths, derived depths and the stage record for the delay line.
    localparam int unsigned IDX_W     = 22;
    localparam int unsigned TS_W      = 2;
    localparam int unsigned HD_W      = 3;
    localparam int unsigned MAX_BASE  = 6;
    localparam int unsigned MAX_EXTRA = (1 << HD_W) - 1;
    localparam int unsigned DEPTH     = MAX_BASE + MAX_EXTRA;
    localparam int unsigned TAP_W     = $clog2(DEPTH);

    typedef struct packed {
        logic             valid;
        logic             win;
        logic             peer;
        logic             miss_all;
        logic [IDX_W-1:0] idx;
    } res_t;

    // Stage index (base delay minus one) for a table-size code; code 3 maps to the longest.
    function automatic logic [TAP_W-1:0] base_tap(input logic [TS_W-1:0] code);
        case (code)
            2'b00:   base_tap = TAP_W'(3);
            2'b01:   base_tap = TAP_W'(4);
            default: base_tap = TAP_W'(MAX_BASE - 1);
        endcase
    endfunction
endpackage

// File: rtl/csr_delay_line.sv
// Fixed-depth register chain holding one search record per stage.
// Two read taps choose the stages seen by the SRAM and flag drivers.
// Assumes the taps stay static while searches are in flight.
module csr_delay_line
    import csr_pkg::*;
#(
    parameter int unsigned N_STAGE = DEPTH,
    parameter int unsigned TW      = $clog2(N_STAGE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  res_t          din,
    input  logic [TW-1:0] tap_sram,
    input  logic [TW-1:0] tap_flag,
    output res_t          q_sram,
    output res_t          q_flag
);
    res_t stage [N_STAGE];

    for (genvar g = 0; g < N_STAGE; g++) begin : g_stage
        if (g == 0) begin : g_head
            // Capture the incoming search record every clock.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[0] <= '0;
                else        stage[0] <= din;
            end
        end else begin : g_body
            // Advance the record one stage per clock.
            always_ff @(posedge clk) begin
                if (!rst_n) stage[g] <= '0;
                else        stage[g] <= stage[g-1];
            end
            // R11: every stage moves on each clock, so no gap and no reordering
            a_r11_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (stage[g] == $past(stage[g-1])));
        end
    end

    // Select the two read stages, guarding out-of-range taps.
    always_comb begin
        q_sram = (int'(tap_sram) < N_STAGE) ? stage[tap_sram] : '0;
        q_flag = (int'(tap_flag) < N_STAGE) ? stage[tap_flag] : '0;
    end

    a_r3_flag_tap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tap_flag) < N_STAGE);
endmodule

// File: rtl/csr_flag_drv.sv
// Drives the found/valid flags and their enable from the delayed record.
// A local win always drives; the last device fills misses and empty cycles
// unless another device claimed the search.
module csr_flag_drv
    import csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  res_t rec,
    input  logic last_dev,
    output logic hit_found,
    output logic hit_valid,
    output logic flag_oe
);
    // Choose the flag values and whether this device owns them.
    always_comb begin
        hit_found = 1'b0;
        hit_valid = 1'b0;
        flag_oe   = 1'b0;
        if (rec.valid && rec.win) begin
            hit_found = 1'b1;
            hit_valid = 1'b1;
            flag_oe   = 1'b1;
        end else if (last_dev && !(rec.valid && rec.peer)) begin
            flag_oe   = 1'b1;
            hit_valid = rec.valid && rec.miss_all;
        end
    end

    // R4: a found flag is only ever shown as a valid, driven result
    a_r4_found_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        hit_found |-> (hit_valid && flag_oe));
    // R7: a device that is not last drives the flags only for a win
    a_r7_not_last_only_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!last_dev && flag_oe) |-> hit_found);
    // R5/R6: the last device never leaves the flags undriven unless a peer claimed
    a_r6_last_owns_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (last_dev && !flag_oe) |-> (rec.valid && rec.peer));
endmodule

// File: rtl/csr_sram_drv.sv
// Drives the SRAM address and strobes and their enables from the delayed record.
// Without a local win the pins carry the idle pattern, driven only by the
// bus owner and only when no other device claimed the search.
module csr_sram_drv
    import csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  res_t             rec,
    input  logic             last_bus,
    output logic [IDX_W-1:0] sram_addr,
    output logic             sram_ce_n,
    output logic             sram_we_n,
    output logic             sram_ale_n,
    output logic             sram_drive,
    output logic             sram_oe_n,
    output logic             sram_oe_drive
);
    // Address and strobes: winning index or the idle pattern.
    always_comb begin
        sram_addr  = '1;
        sram_ce_n  = 1'b1;
        sram_we_n  = 1'b1;
        sram_ale_n = 1'b1;
        sram_drive = 1'b0;
        if (rec.valid && rec.win) begin
            sram_addr  = rec.idx;
            sram_ce_n  = 1'b0;
            sram_ale_n = 1'b0;
            sram_drive = 1'b1;
        end else if (last_bus && !(rec.valid && rec.peer)) begin
            sram_drive = 1'b1;
        end
    end

    // Output-enable strobe: low whenever some device reads the SRAM this cycle.
    always_comb begin
        sram_oe_n     = !(rec.valid && (rec.win || rec.peer));
        sram_oe_drive = last_bus;
    end

    // R9: a driven bus with the chip disabled must show the all-ones address
    a_r9_idle_pattern: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_drive && sram_ce_n) |-> ((&sram_addr) && sram_we_n && sram_ale_n));
    // R8: a selected chip always comes with the address latch and a read
    a_r8_win_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_ce_n |-> (sram_drive && !sram_ale_n && sram_we_n));
endmodule

// File: rtl/cascade_result_delay.sv
// Top of the cascaded search-result delay pipeline. Encodes each incoming
// search, delays it through one shared chain, and taps it at the base delay
// for the SRAM pins and at base plus extra delay for the flags.
// Assumes the configuration is static between resets.
module cascade_result_delay
    import csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TS_W-1:0]  cfg_table_size,
    input  logic [HD_W-1:0]  cfg_hit_delay,
    input  logic             cfg_last_dev,
    input  logic             cfg_last_bus,
    input  logic             req_valid,
    input  logic             req_hit,
    input  logic [IDX_W-1:0] req_index,
    input  logic             peer_claim,
    output logic             hit_found,
    output logic             hit_valid,
    output logic             flag_oe,
    output logic [IDX_W-1:0] sram_addr,
    output logic             sram_ce_n,
    output logic             sram_we_n,
    output logic             sram_ale_n,
    output logic             sram_drive,
    output logic             sram_oe_n,
    output logic             sram_oe_drive,
    output logic             cfg_err
);
    res_t             din;
    res_t             rec_sram;
    res_t             rec_flag;
    logic [TAP_W-1:0] tap_sram;
    logic [TAP_W-1:0] tap_flag;

    // Classify the search against the rest of the cascade.
    always_comb begin
        din.valid    = req_valid;
        din.win      = req_valid && req_hit && !peer_claim;
        din.peer     = req_valid && peer_claim;
        din.miss_all = req_valid && !req_hit && !peer_claim;
        din.idx      = req_index;
    end

    // Derive the two read stages and the reserved-code flag.
    always_comb begin
        tap_sram = base_tap(cfg_table_size);
        tap_flag = tap_sram + TAP_W'(cfg_hit_delay);
        cfg_err  = (cfg_table_size == 2'b11);
    end

    csr_delay_line #(.N_STAGE(DEPTH), .TW(TAP_W)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .tap_sram (tap_sram),
        .tap_flag (tap_flag),
        .q_sram   (rec_sram),
        .q_flag   (rec_flag)
    );

    csr_flag_drv u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .rec       (rec_flag),
        .last_dev  (cfg_last_dev),
        .hit_found (hit_found),
        .hit_valid (hit_valid),
        .flag_oe   (flag_oe)
    );

    csr_sram_drv u_sram (
        .clk           (clk),
        .rst_n         (rst_n),
        .rec           (rec_sram),
        .last_bus      (cfg_last_bus),
        .sram_addr     (sram_addr),
        .sram_ce_n     (sram_ce_n),
        .sram_we_n     (sram_we_n),
        .sram_ale_n    (sram_ale_n),
        .sram_drive    (sram_drive),
        .sram_oe_n     (sram_oe_n),
        .sram_oe_drive (sram_oe_drive)
    );

    // R2: the reserved code must land on the longest base delay
    a_r2_reserved_longest: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (tap_sram == TAP_W'(MAX_BASE - 1)));
    // R10: while this device owns the strobe, its own win pulls it low
    a_r10_oe_on_own_win: assert property (@(posedge clk) disable iff (!rst_n)
        (sram_oe_drive && !sram_ce_n) |-> !sram_oe_n);
    // R3: flags are never shown before the SRAM pins of the same search
    a_r3_flag_after_sram: assert property (@(posedge clk) disable iff (!rst_n)
        tap_flag >= tap_sram);
endmodule

// File: tb/cascade_result_delay_tb.sv
`timescale 1ns/1ps
module cascade_result_delay_tb;
    localparam int NREQ = 24;
    localparam int NCYC = NREQ + 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_table_size = '0;
    logic [2:0]  cfg_hit_delay = '0;
    logic        cfg_last_dev = 1'b0;
    logic        cfg_last_bus = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_hit = 1'b0;
    logic [21:0] req_index = '0;
    logic        peer_claim = 1'b0;
    logic        hit_found, hit_valid, flag_oe;
    logic [21:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_ale_n, sram_drive, sram_oe_n, sram_oe_drive, cfg_err;

    int vectors = 0;
    int fails = 0;
    logic        rv [NREQ];
    logic        rh [NREQ];
    logic        rp [NREQ];
    logic [21:0] ri [NREQ];

    always #2 clk = ~clk;

    cascade_result_delay u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_table_size(cfg_table_size), .cfg_hit_delay(cfg_hit_delay),
        .cfg_last_dev(cfg_last_dev), .cfg_last_bus(cfg_last_bus),
        .req_valid(req_valid), .req_hit(req_hit), .req_index(req_index),
        .peer_claim(peer_claim),
        .hit_found(hit_found), .hit_valid(hit_valid), .flag_oe(flag_oe),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_ale_n(sram_ale_n), .sram_drive(sram_drive), .sram_oe_n(sram_oe_n),
        .sram_oe_drive(sram_oe_drive), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s ts=%0d hd=%0d ld=%0b lb=%0b actual=%h expected=%h",
                     req, cfg_table_size, cfg_hit_delay, cfg_last_dev, cfg_last_bus, act, exp);
        end
    endtask

    // Compare both output groups for cycle cyc with the searches L and L+H cycles back.
    task automatic check_cycle(input int cyc, input int lat, input int hd);
        int s = cyc - lat;       // R1: SRAM pins due L cycles after issue
        int f = cyc - lat - hd;  // R3: flags due L+H cycles after issue
        logic v, w, p, m;
        logic [21:0] ix;
        logic [2:0] ef;
        logic [25:0] es;
        string tag;
        // flag group
        v = (f >= 0 && f < NREQ) ? rv[f] : 1'b0;
        w = v && rh[f] && !rp[f];
        p = v && rp[f];
        m = v && !rh[f] && !rp[f];
        if (w)                      begin ef = 3'b111; tag = "R4"; end
        else if (cfg_last_dev && !p) begin ef = {1'b1, 1'b0, m}; tag = m ? "R5" : "R6"; end
        else                        begin ef = 3'b000; tag = cfg_last_dev ? "R6" : "R7"; end
        if (cyc == 0) tag = "R12";
        check(tag, {29'b0, flag_oe, hit_found, hit_valid}, {29'b0, ef});
        // SRAM group
        v = (s >= 0 && s < NREQ) ? rv[s] : 1'b0;
        ix = (s >= 0 && s < NREQ) ? ri[s] : '0;
        w = v && rh[s] && !rp[s];
        p = v && rp[s];
        if (w)                       begin es = {1'b1, 1'b0, 1'b1, 1'b0, ix}; tag = "R8"; end
        else if (cfg_last_bus && !p) begin es = {4'b1111, 22'h3FFFFF}; tag = "R9"; end
        else                         begin es = {4'b0111, 22'h3FFFFF}; tag = "R9"; end
        if (cyc == 0) tag = "R12";
        check(tag, {6'b0, sram_drive, sram_ce_n, sram_we_n, sram_ale_n, sram_addr}, {6'b0, es});
        // R10: strobe ownership and value
        check("R10", {30'b0, sram_oe_drive, sram_oe_n}, {30'b0, cfg_last_bus, !(w || p)});
    endtask

    task automatic run_cfg(input int ts, input int hd, input bit ld, input bit lb, input int cid);
        int lat = (ts == 0) ? 4 : (ts == 1) ? 5 : 6;   // R1, R2: code 3 behaves as 6
        for (int k = 0; k < NREQ; k++) begin
            int pp = k * 7 + cid * 3;
            rv[k] = (pp % 6) != 5;   // mostly back-to-back searches (R11)
            rh[k] = (pp % 3) != 0;
            rp[k] = (pp % 4) == 2;
            ri[k] = 22'((pp * 9973 + cid) & 32'h1FFFFF);
        end
        cfg_table_size = 2'(ts);
        cfg_hit_delay  = 3'(hd);
        cfg_last_dev   = ld;
        cfg_last_bus   = lb;
        req_valid      = 1'b0;
        rst_n          = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R2", {31'b0, cfg_err}, {31'b0, (ts == 3)});
        for (int c = 0; c < NCYC; c++) begin
            check_cycle(c, lat, hd);
            if (c < NREQ) begin
                req_valid  = rv[c];
                req_hit    = rh[c];
                peer_claim = rp[c];
                req_index  = ri[c];
            end else begin
                req_valid  = 1'b0;
                req_hit    = 1'b0;
                peer_claim = 1'b0;
                req_index  = '0;
            end
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int cid = 0;
        @(negedge clk);
        for (int ts = 0; ts < 4; ts++)
            for (int hd = 0; hd < 8; hd++)
                for (int fl = 0; fl < 4; fl++) begin
                    run_cfg(ts, hd, fl[0], fl[1], cid);
                    cid++;
                end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule